// File: doc/BRIEF.md
# Flash Command and Lock Sequencer

This block sits between a register interface and an on-chip flash array of 1024 pages. Software writes a command word with a key byte, an opcode and a page number. The block decides whether the command may run. It drives the array through an erase/write busy-timer stub whose phase lengths are parameters in clock cycles. When the command ends, it reports completion. Five commands exist: page program, page erase, full erase, set region lock and clear region lock.

The block keeps sixteen region lock bits. Each region covers sixteen consecutive pages, so only pages 0 to 255 can be protected. A command is refused in any of these cases:
- the key is wrong;
- the block is already busy;
- the opcode is unknown;
- the command would alter a protected region.

A refused command raises one of two error flags, and each flag can request an interrupt. A separate read-wait path acknowledges array read requests after a programmed number of wait states, from 0 to 3.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o, lock_err_o, prog_err_o, irq_o, rd_ack_o, arr_erase_o and arr_write_o are 0, lock_bits_o is all zero and the wait-state count is 0.
- R2: A command whose cmd_key_i differs from KEY (default 8'hA5) starts nothing and sets prog_err_o.
- R3: An accepted command keeps busy_o high for exactly PROG_CYC cycles for page program (opcode 1), PERASE_CYC for page erase (opcode 2), FERASE_CYC for full erase (opcode 3) and LOCK_CYC for set lock (opcode 4) or clear lock (opcode 5). busy_o rises in the cycle after the command is sampled.
- R4: A command sampled while busy_o is high is ignored: the running command's length and effects are unchanged, and prog_err_o is set.
- R5: Page program first holds arr_erase_o for PERASE_CYC cycles and then arr_write_o for PROG_CYC-PERASE_CYC cycles. The two are never high together, and arr_page_o carries the commanded page.
- R6: Set lock (4) sets, and clear lock (5) clears, lock_bits_o bit cmd_page_i[7:4] when the command ends. A lock command naming a page of 256 or above is refused and sets prog_err_o.
- R7: Page program or page erase on a page below 256 whose region bit (page[7:4]) is set is refused and sets lock_err_o. Pages 256 and above are never refused for locking.
- R8: Full erase is refused, setting lock_err_o, when any lock bit is set.
- R9: done_o clears when a command starts, rises in the same cycle busy_o falls, and stays high until the next start.
- R10: A pulse on stat_rd_i clears lock_err_o and prog_err_o. An error raised in the same cycle wins.
- R11: irq_o is high exactly when an enabled flag is high. Enable bit 0 selects done_o, bit 1 lock_err_o and bit 2 prog_err_o; cfg_we_i loads the enables and the wait-state count.
- R12: A single-cycle rd_req_i with wait-state count W makes rd_ack_o high for exactly one cycle, the (W+1)th cycle after the request cycle. Requests made while a read is pending are ignored.
- R13: Opcodes 0, 6 and 7 start nothing and set prog_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_key_i | input | 8 | Command key field |
| cmd_op_i | input | 3 | Command opcode |
| cmd_page_i | input | 10 | Target page number |
| stat_rd_i | input | 1 | Status read strobe, clears error flags |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ws_i | input | 2 | Read wait-state count |
| cfg_ie_i | input | 3 | Interrupt enables {prog, lock, done} |
| rd_req_i | input | 1 | Array read request pulse |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Last command ended |
| lock_err_o | output | 1 | Command refused by region lock |
| prog_err_o | output | 1 | Command refused by key, busy or opcode |
| irq_o | output | 1 | Interrupt request |
| lock_bits_o | output | 16 | Region lock bits |
| arr_erase_o | output | 1 | Array erase phase active |
| arr_write_o | output | 1 | Array write phase active |
| arr_page_o | output | 10 | Page of the running command |
| rd_ack_o | output | 1 | Read data valid |

## Verification
The assertions check four things on every cycle:
- no command starts while one is running;
- a started program or erase never targets a locked region, and a full erase only starts with every region unlocked;
- a wrong key never raises busy, and done is high whenever busy falls;
- erase and write never overlap, write only follows erase, and a read acknowledge lasts one cycle.

Exact phase lengths, lock bit updates when a command ends, error flag clearing on status reads and the wait-state latency can only be shown by the bench's scenarios. Its randomized command mix is compared against a reference lock and verdict model.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_PERASE = 3'd2;
  localparam logic [2:0] OP_FERASE = 3'd3;
  localparam logic [2:0] OP_SLOCK  = 3'd4;
  localparam logic [2:0] OP_CLOCK  = 3'd5;

  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_WRITE, PH_HOLD} fcs_phase_e;
  typedef enum logic [1:0] {VD_START, VD_LOCK_ERR, VD_PROG_ERR} fcs_verdict_e;
endpackage

// File: rtl/fcs_cmd_check.sv
module fcs_cmd_check
  import fcs_pkg::*;
#(
  parameter int PAGE_W    = 10,
  parameter int NREG      = 16,
  parameter int REG_PAGES = 16
) (
  input  logic              key_ok_i,
  input  logic              busy_i,
  input  logic [2:0]        op_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [NREG-1:0]   lock_i,
  output logic              lockable_o,
  output fcs_verdict_e      verdict_o
);
  localparam int REG_W = $clog2(NREG);
  localparam int RPG_W = $clog2(REG_PAGES);
  localparam logic [PAGE_W:0] SPAN = (PAGE_W+1)'(NREG * REG_PAGES);

  logic [REG_W-1:0] region;
  logic             region_locked;

  assign lockable_o    = {1'b0, page_i} < SPAN;
  assign region        = page_i[RPG_W +: REG_W];
  assign region_locked = lockable_o && lock_i[region];

  always_comb begin
    verdict_o = VD_START;
    if (busy_i || !key_ok_i) verdict_o = VD_PROG_ERR;
    else begin
      case (op_i)
        OP_PROG, OP_PERASE: if (region_locked) verdict_o = VD_LOCK_ERR;
        OP_FERASE:          if (|lock_i) verdict_o = VD_LOCK_ERR;
        OP_SLOCK, OP_CLOCK: if (!lockable_o) verdict_o = VD_PROG_ERR;
        default:            verdict_o = VD_PROG_ERR;
      endcase
    end
  end
endmodule

// File: rtl/fcs_timer.sv
module fcs_timer
  import fcs_pkg::*;
#(
  parameter int PROG_CYC   = 60,
  parameter int PERASE_CYC = 20,
  parameter int FERASE_CYC = 150,
  parameter int LOCK_CYC   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] op_i,
  output logic       busy_o,
  output logic       erase_o,
  output logic       write_o,
  output logic       end_o
);
  localparam int M1    = (PROG_CYC > FERASE_CYC) ? PROG_CYC : FERASE_CYC;
  localparam int MAXC  = (M1 > LOCK_CYC) ? M1 : LOCK_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  fcs_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             then_write_q;
  logic             chain;

  assign chain   = (phase_q == PH_ERASE) && then_write_q;
  assign busy_o  = phase_q != PH_IDLE;
  assign erase_o = phase_q == PH_ERASE;
  assign write_o = phase_q == PH_WRITE;
  assign end_o   = busy_o && (cnt_q == '0) && !chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      then_write_q <= 1'b0;
    end else if (start_i) begin
      then_write_q <= op_i == OP_PROG;
      case (op_i)
        OP_PROG, OP_PERASE: begin
          phase_q <= PH_ERASE;
          cnt_q   <= CNT_W'(PERASE_CYC - 1);
        end
        OP_FERASE: begin
          phase_q <= PH_ERASE;
          cnt_q   <= CNT_W'(FERASE_CYC - 1);
        end
        default: begin
          phase_q <= PH_HOLD;
          cnt_q   <= CNT_W'(LOCK_CYC - 1);
        end
      endcase
    end else if (busy_o) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (chain) begin
        phase_q      <= PH_WRITE;
        cnt_q        <= CNT_W'(PROG_CYC - PERASE_CYC - 1);
        then_write_q <= 1'b0;
      end else phase_q <= PH_IDLE;
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R4
  AST_ERASE_WRITE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_o && write_o)); // R5
  AST_WRITE_AFTER_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(write_o) |-> $past(erase_o)); // R5
endmodule

// File: rtl/fcs_rd_wait.sv
module fcs_rd_wait #(
  parameter int WS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WS_W-1:0] ws_i,
  input  logic            req_i,
  output logic            ack_o
);
  logic            pend_q;
  logic [WS_W-1:0] cnt_q;

  assign ack_o = pend_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!pend_q) begin
      if (req_i) begin
        pend_q <= 1'b1;
        cnt_q  <= ws_i;
      end
    end else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    else pend_q <= 1'b0;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R12
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int          PAGE_W     = 10,
  parameter int          NREG       = 16,
  parameter int          REG_PAGES  = 16,
  parameter int          KEY_W      = 8,
  parameter logic [7:0]  KEY        = 8'hA5,
  parameter int          WS_W       = 2,
  parameter int          PROG_CYC   = 60,
  parameter int          PERASE_CYC = 20,
  parameter int          FERASE_CYC = 150,
  parameter int          LOCK_CYC   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [KEY_W-1:0]  cmd_key_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [PAGE_W-1:0] cmd_page_i,
  input  logic              stat_rd_i,
  input  logic              cfg_we_i,
  input  logic [WS_W-1:0]   cfg_ws_i,
  input  logic [2:0]        cfg_ie_i,
  input  logic              rd_req_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              lock_err_o,
  output logic              prog_err_o,
  output logic              irq_o,
  output logic [NREG-1:0]   lock_bits_o,
  output logic              arr_erase_o,
  output logic              arr_write_o,
  output logic [PAGE_W-1:0] arr_page_o,
  output logic              rd_ack_o
);
  localparam int REG_W = $clog2(NREG);
  localparam int RPG_W = $clog2(REG_PAGES);

  fcs_verdict_e      verdict;
  logic              lockable, start, t_end;
  logic [WS_W-1:0]   ws_q;
  logic [2:0]        ie_q, pend_op_q;
  logic [NREG-1:0]   lock_q;
  logic [REG_W-1:0]  pend_reg_q;
  logic [PAGE_W-1:0] page_q;
  logic              done_q, lock_err_q, prog_err_q;

  fcs_cmd_check #(.PAGE_W(PAGE_W), .NREG(NREG), .REG_PAGES(REG_PAGES)) u_check (
    .key_ok_i   (cmd_key_i == KEY_W'(KEY)),
    .busy_i     (busy_o),
    .op_i       (cmd_op_i),
    .page_i     (cmd_page_i),
    .lock_i     (lock_q),
    .lockable_o (lockable),
    .verdict_o  (verdict)
  );

  assign start = cmd_valid_i && (verdict == VD_START);

  fcs_timer #(.PROG_CYC(PROG_CYC), .PERASE_CYC(PERASE_CYC),
              .FERASE_CYC(FERASE_CYC), .LOCK_CYC(LOCK_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .op_i    (cmd_op_i),
    .busy_o  (busy_o),
    .erase_o (arr_erase_o),
    .write_o (arr_write_o),
    .end_o   (t_end)
  );

  fcs_rd_wait #(.WS_W(WS_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ws_i   (ws_q),
    .req_i  (rd_req_i),
    .ack_o  (rd_ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q       <= '0;
      ie_q       <= '0;
      lock_q     <= '0;
      pend_op_q  <= '0;
      pend_reg_q <= '0;
      page_q     <= '0;
      done_q     <= 1'b0;
      lock_err_q <= 1'b0;
      prog_err_q <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        ws_q <= cfg_ws_i;
        ie_q <= cfg_ie_i;
      end
      if (start) begin
        pend_op_q  <= cmd_op_i;
        pend_reg_q <= cmd_page_i[RPG_W +: REG_W];
        page_q     <= cmd_page_i;
        done_q     <= 1'b0;
      end else if (t_end) begin
        done_q <= 1'b1;
        if (pend_op_q == OP_SLOCK) lock_q[pend_reg_q] <= 1'b1;
        if (pend_op_q == OP_CLOCK) lock_q[pend_reg_q] <= 1'b0;
      end
      if (cmd_valid_i && verdict == VD_LOCK_ERR) lock_err_q <= 1'b1;
      else if (stat_rd_i) lock_err_q <= 1'b0;
      if (cmd_valid_i && verdict == VD_PROG_ERR) prog_err_q <= 1'b1;
      else if (stat_rd_i) prog_err_q <= 1'b0;
    end
  end

  assign done_o      = done_q;
  assign lock_err_o  = lock_err_q;
  assign prog_err_o  = prog_err_q;
  assign lock_bits_o = lock_q;
  assign arr_page_o  = page_q;
  assign irq_o       = |({prog_err_q, lock_err_q, done_q} & ie_q);

  AST_BAD_KEY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_key_i != KEY_W'(KEY)) |=> !busy_o); // R2
  AST_LOCKED_NOT_STARTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && (cmd_op_i == OP_PROG || cmd_op_i == OP_PERASE) && lockable)
      |-> !lock_q[cmd_page_i[RPG_W +: REG_W]]); // R7
  AST_FULL_NEEDS_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && cmd_op_i == OP_FERASE) |-> (lock_q == '0)); // R8
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R9
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int PROG_CYC = 60, PERASE_CYC = 20, FERASE_CYC = 150, LOCK_CYC = 10;
  localparam logic [7:0] KEY = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, stat_rd = 0, cfg_we = 0, rd_req = 0;
  logic [7:0] cmd_key = 0;
  logic [2:0] cmd_op = 0, cfg_ie = 0;
  logic [9:0] cmd_page = 0;
  logic [1:0] cfg_ws = 0;
  logic busy, done, lock_err, prog_err, irq, arr_erase, arr_write, rd_ack;
  logic [15:0] lock_bits;
  logic [9:0] arr_page;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] m_lock = '0;

  always #5 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_key_i(cmd_key),
    .cmd_op_i(cmd_op), .cmd_page_i(cmd_page), .stat_rd_i(stat_rd), .cfg_we_i(cfg_we),
    .cfg_ws_i(cfg_ws), .cfg_ie_i(cfg_ie), .rd_req_i(rd_req), .busy_o(busy), .done_o(done),
    .lock_err_o(lock_err), .prog_err_o(prog_err), .irq_o(irq), .lock_bits_o(lock_bits),
    .arr_erase_o(arr_erase), .arr_write_o(arr_write), .arr_page_o(arr_page), .rd_ack_o(rd_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // 0 start, 1 lock error, 2 prog error
  function automatic int exp_verdict(input logic [2:0] op, input logic [7:0] key,
                                     input logic [9:0] page, input logic [15:0] lk);
    if (key != KEY) return 2;
    case (op)
      3'd1, 3'd2: return (page < 10'd256 && lk[page[7:4]]) ? 1 : 0;
      3'd3: return (lk != 0) ? 1 : 0;
      3'd4, 3'd5: return (page < 10'd256) ? 0 : 2;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_dur(input logic [2:0] op);
    case (op)
      3'd1: return PROG_CYC;
      3'd2: return PERASE_CYC;
      3'd3: return FERASE_CYC;
      default: return LOCK_CYC;
    endcase
  endfunction

  task automatic issue(input logic [2:0] op, input logic [7:0] key, input logic [9:0] page);
    cmd_valid = 1; cmd_op = op; cmd_key = key; cmd_page = page;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic stat_read();
    stat_rd = 1; @(posedge clk); @(negedge clk); stat_rd = 0;
  endtask

  task automatic cfg(input logic [1:0] ws, input logic [2:0] ie);
    cfg_we = 1; cfg_ws = ws; cfg_ie = ie; @(posedge clk); @(negedge clk); cfg_we = 0;
  endtask

  // Called in cycle 1 after issue; returns busy length
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, ne, nw;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 errs", {lock_err, prog_err, irq, rd_ack}, 0);
    check("R1 locks", lock_bits, 0); check("R1 array", {arr_erase, arr_write}, 0);
    rst_n = 1; @(negedge clk);

    // R2 bad key
    issue(3'd2, 8'h5A, 10'd300);
    check("R2 busy", busy, 0); check("R2 prog_err", prog_err, 1);
    // R10 status read clears
    stat_read(); check("R10 clear", {lock_err, prog_err}, 0);

    // R13 invalid opcodes
    for (int o = 0; o < 8; o += 6) begin
      issue(3'(o), KEY, 10'd5);
      check("R13 busy", busy, 0); check("R13 prog_err", prog_err, 1);
      stat_read();
    end
    issue(3'd7, KEY, 10'd5); check("R13 op7", {busy, prog_err}, 2'b01); stat_read();

    // R5 / R3 page program with auto erase
    issue(3'd1, KEY, 10'd700);
    check("R9 done cleared", done, 0);
    check("R5 page", arr_page, 700);
    ne = 0; nw = 0; n = 0;
    while (busy && n < 1000) begin
      if (arr_erase && arr_write) check("R5 overlap", 1, 0);
      if (arr_erase) begin ne++; if (nw != 0) check("R5 order", 1, 0); end
      if (arr_write) nw++;
      n++; @(negedge clk);
    end
    check("R3 prog dur", n, PROG_CYC);
    check("R5 erase", ne, PERASE_CYC);
    check("R5 write", nw, PROG_CYC - PERASE_CYC);
    check("R9 done set", done, 1);

    // R4 command while busy
    issue(3'd2, KEY, 10'd400);
    @(negedge clk);
    issue(3'd4, KEY, 10'd16);
    check("R4 prog_err", prog_err, 1);
    wait_idle(n);
    check("R4 dur unchanged", n + 2, PERASE_CYC);
    check("R4 lock untouched", lock_bits, 0);
    stat_read();

    // R6 set lock region 3, R7 refusal, R8 full erase refusal
    issue(3'd4, KEY, 10'd55); wait_idle(n);
    check("R3 lock dur", n, LOCK_CYC); check("R6 set", lock_bits, 16'h0008);
    m_lock = 16'h0008;
    issue(3'd1, KEY, 10'd48);
    check("R7 refused", {busy, lock_err}, 2'b01); stat_read();
    issue(3'd2, KEY, 10'd304);
    check("R7 high page", busy, 1); wait_idle(n);
    issue(3'd3, KEY, 10'd0);
    check("R8 refused", {busy, lock_err}, 2'b01);
    issue(3'd4, KEY, 10'd256);
    check("R6 high page", {busy, prog_err}, 2'b01);
    // R11 irq
    check("R11 off", irq, 0);
    cfg(2'd0, 3'b010); check("R11 lock", irq, 1);
    cfg(2'd0, 3'b001); check("R11 done", irq, 1);
    // R10 same-cycle error wins
    stat_rd = 1; issue(3'd0, KEY, 10'd0); stat_rd = 0;
    check("R10 win", {lock_err, prog_err}, 2'b01);
    stat_read();
    issue(3'd5, KEY, 10'd60); wait_idle(n);
    check("R6 clear", lock_bits, 0); m_lock = 0;
    issue(3'd3, KEY, 10'd0); wait_idle(n);
    check("R3 full dur", n, FERASE_CYC);
    cfg(2'd0, 3'b000);

    // R12 wait states
    for (int w = 0; w < 4; w++) begin
      cfg(2'(w), 3'b000);
      rd_req = 1; @(posedge clk); @(negedge clk); rd_req = 0;
      n = 1;
      while (!rd_ack && n < 10) begin n++; @(negedge clk); end
      check("R12 latency", n, w + 1);
      @(negedge clk); check("R12 single", rd_ack, 0);
    end

    // Random mix against model
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op; logic [7:0] key; logic [9:0] page; int v;
      op = 3'($urandom_range(0, 7));
      key = ($urandom_range(0, 4) == 0) ? 8'($urandom) : KEY;
      if (key == KEY && $urandom_range(0, 4) == 0) key = 8'h00;
      page = ($urandom_range(0, 1) != 0) ? 10'($urandom_range(0, 255)) : 10'($urandom);
      if (op == 3'd3 && $urandom_range(0, 1) != 0) op = 3'd5;
      v = exp_verdict(op, key, page, m_lock);
      issue(op, key, page);
      if (v == 0) begin
        wait_idle(n);
        check("R3 rand dur", n, exp_dur(op));
        if (op == 3'd4) m_lock[page[7:4]] = 1'b1;
        if (op == 3'd5) m_lock[page[7:4]] = 1'b0;
        check("R6 rand locks", lock_bits, m_lock);
        check("R9 rand done", done, 1);
      end else begin
        check("R7 rand verdict", {busy, lock_err, prog_err}, (v == 1) ? 3'b010 : 3'b001);
        stat_read();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule